// File: doc/BRIEF.md
# OS Tick Timer with Timestamp Counter

This block gives an operating system a tick source and a time base. It has two counters. The first is a free-running 32-bit timestamp that advances by one on every clock. The second is a down-counter that raises an interrupt when it runs out, either once or repeatedly. Both counters are controlled through a small register bus.

Software programs the down-counter with one 32-bit word. The two lowest bits of that word are control flags, so the count is always a multiple of four. Each time the down-counter expires it sets a sticky pending flag. That flag drives the interrupt pin until software clears it by writing a one to it.

The request side of the bus uses a valid/ready handshake. `req_ready` is always high, so a request is accepted in any cycle where `req_valid` is high. Reads are answered one cycle later with a single `rsp_valid` pulse. The response side has no back-pressure, and the requester must take the data in the cycle it appears. Writes produce no response.

Top module: `tmr_os_tick`

## Requirements
- R1: After reset, the timestamp, the reload word, the down-counter and the pending flag all read zero, and `irq` is low.
- R2: The register map is: address 0 is the timestamp, address 1 is the reload word, address 2 is status (bit 0 holds pending), and address 3 is the current down-count, which is read-only. A write to address 3 changes nothing.
- R3: A write to the reload word loads the down-counter in that same cycle with the written value with bits [1:0] forced to zero. Bit 0 of the word is enable and bit 1 is one-shot. The word reads back as {count bits, one-shot, enable}.
- R4: While enable is set and the down-counter is not zero, it decrements by one per clock. While enable is clear, it holds its value.
- R5: When one-shot is clear, the counter reloads from the count bits in the cycle where it steps from 1 to 0, so it expires every 4*N clocks, where N is the value of bits [31:2].
- R6: When one-shot is set, the counter stops at zero after its first expiry, and the enable bit reads back as zero.
- R7: Every expiry sets the pending flag. Writing 1 to status bit 0 clears it, and writing 0 has no effect. If an expiry and a clear fall in the same cycle, the expiry wins.
- R8: `irq` is high exactly when the pending flag is set.
- R9: Writing zero to the reload word stops the timer and leaves the down-counter at zero.
- R10: The timestamp increments on every clock and wraps from all-ones to zero. A write loads the written value, and counting continues from that value.
- R11: `req_ready` is always high. A read accepted on one clock edge gives `rsp_valid` high for one cycle after that edge. The read data is the register value from before any update made on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 2 | Register select |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| irq | output | 1 | Interrupt, equal to the pending flag |

## Verification
Randomly drawn reload counts, modes and wait times are checked against a closed-form model of the remaining count and the interrupt level. This separates an off-by-one in the expiry cycle, a missing reload, and a one-shot timer that keeps running. Directed cases cover the following:
- An expiry that coincides with a clear, which shows whether set takes priority.
- A write of zero to the reload word.
- Toggling only the enable bit.
- A write to the read-only count register.
- Timestamp wrap, which shows whether the timestamp wraps or saturates.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned CTRL_W      = 2;
  localparam int unsigned EN_BIT      = 0;
  localparam int unsigned ONESHOT_BIT = 1;
  localparam int unsigned ADDR_W      = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_STAMP  = 2'd0,
    REG_RELOAD = 2'd1,
    REG_STATUS = 2'd2,
    REG_COUNT  = 2'd3
  } tmr_reg_e;
endpackage

// File: rtl/tmr_stamp.sv
module tmr_stamp #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  output logic [DATA_W-1:0] stamp
);
  always_ff @(posedge clk) begin
    if (!rst_n)    stamp <= '0;
    else if (load) stamp <= load_val;
    else           stamp <= stamp + 1'b1;
  end

  AST_STAMP_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> stamp == $past(stamp) + 1'b1); // R10
endmodule

// File: rtl/tmr_downcounter.sv
module tmr_downcounter
  import tmr_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_word,
  output logic [DATA_W-1:0] count,
  output logic [DATA_W-1:0] reload_word,
  output logic              expire
);
  localparam int unsigned FIELD_W = DATA_W - CTRL_W;

  logic [FIELD_W-1:0] field_q;
  logic               en_q;
  logic               oneshot_q;
  logic               at_one;

  assign at_one      = (count == {{(DATA_W-1){1'b0}}, 1'b1});
  assign expire      = !load && en_q && at_one;
  assign reload_word = {field_q, oneshot_q, en_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      field_q   <= '0;
      en_q      <= 1'b0;
      oneshot_q <= 1'b0;
      count     <= '0;
    end else if (load) begin
      field_q   <= load_word[DATA_W-1:CTRL_W];
      en_q      <= load_word[EN_BIT];
      oneshot_q <= load_word[ONESHOT_BIT];
      count     <= {load_word[DATA_W-1:CTRL_W], {CTRL_W{1'b0}}};
    end else if (en_q && count != '0) begin
      if (at_one) begin
        if (oneshot_q) begin
          en_q  <= 1'b0;
          count <= '0;
        end else begin
          count <= {field_q, {CTRL_W{1'b0}}};
        end
      end else begin
        count <= count - 1'b1;
      end
    end
  end

  AST_LOAD_TAKES_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> count[CTRL_W-1:0] == '0); // R3
  AST_COUNT_DECREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && en_q && count > 1) |=> count == $past(count) - 1'b1); // R4
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !en_q) |=> $stable(count)); // R4
  AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !oneshot_q) |=> count == {$past(field_q), {CTRL_W{1'b0}}}); // R5
  AST_ONESHOT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && oneshot_q) |=> (!en_q && count == '0)); // R6
endmodule

// File: rtl/tmr_regbus.sv
module tmr_regbus
  import tmr_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              clr_bit,
  input  logic [DATA_W-1:0] stamp,
  input  logic [DATA_W-1:0] reload_word,
  input  logic [DATA_W-1:0] count,
  input  logic              expire,
  output logic              wr_stamp,
  output logic              wr_reload,
  output logic              pending,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  logic              wr_status;
  logic              rd_req;
  logic [DATA_W-1:0] rd_mux;

  assign rd_req    = req_valid && !req_write;
  assign wr_stamp  = req_valid && req_write && (req_addr == REG_STAMP);
  assign wr_reload = req_valid && req_write && (req_addr == REG_RELOAD);
  assign wr_status = req_valid && req_write && (req_addr == REG_STATUS);

  always_comb begin
    unique case (tmr_reg_e'(req_addr))
      REG_STAMP:  rd_mux = stamp;
      REG_RELOAD: rd_mux = reload_word;
      REG_STATUS: rd_mux = {{(DATA_W-1){1'b0}}, pending};
      REG_COUNT:  rd_mux = count;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                    pending <= 1'b0;
    else if (expire)               pending <= 1'b1;
    else if (wr_status && clr_bit) pending <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_req;
      if (rd_req) rsp_rdata <= rd_mux;
    end
  end

  AST_EXPIRY_SETS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> pending); // R7
  AST_ZERO_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_status && !clr_bit && pending) |=> pending); // R7
  AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rsp_valid); // R11
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rsp_valid); // R11
endmodule

// File: rtl/tmr_os_tick.sv
module tmr_os_tick
  import tmr_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              irq
);
  logic [DATA_W-1:0] stamp;
  logic [DATA_W-1:0] count;
  logic [DATA_W-1:0] reload_word;
  logic              expire;
  logic              wr_stamp;
  logic              wr_reload;
  logic              pending;

  assign req_ready = 1'b1;
  assign irq       = pending;

  tmr_stamp #(.DATA_W(DATA_W)) u_stamp (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wr_stamp),
    .load_val (req_wdata),
    .stamp    (stamp)
  );

  tmr_downcounter #(.DATA_W(DATA_W)) u_down (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (wr_reload),
    .load_word   (req_wdata),
    .count       (count),
    .reload_word (reload_word),
    .expire      (expire)
  );

  tmr_regbus #(.DATA_W(DATA_W)) u_bus (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .clr_bit     (req_wdata[0]),
    .stamp       (stamp),
    .reload_word (reload_word),
    .count       (count),
    .expire      (expire),
    .wr_stamp    (wr_stamp),
    .wr_reload   (wr_reload),
    .pending     (pending),
    .rsp_valid   (rsp_valid),
    .rsp_rdata   (rsp_rdata)
  );

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(expire)); // R8
endmodule

// File: tb/test_tmr_os_tick.sv
module test_tmr_os_tick;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [1:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tmr_os_tick i_tmr_os_tick (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq(irq)
  );

  function automatic logic [31:0] exp_count(int n, bit os, int k);
    int p = 4 * n;
    if (os) return (k < p) ? 32'(p - k) : 32'd0;
    return 32'(p - (k % p));
  endfunction

  function automatic logic [31:0] exp_reload(int n, bit os, int k);
    logic [29:0] f = 30'(n);
    bit en = !(os && k >= 4 * n);
    return {f, os, en};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(logic [1:0] a, logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    check("R11 rsp_valid", {31'b0, rsp_valid}, 32'd1);
    d = rsp_rdata;
  endtask

  task automatic wait_cyc(int j);
    repeat (j) @(negedge clk);
  endtask

  initial begin
    logic [31:0] d;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 irq", {31'b0, irq}, 32'd0);
    check("R11 ready", {31'b0, req_ready}, 32'd1);
    rd(2'd1, d); check("R1 reload", d, 32'd0);
    rd(2'd3, d); check("R1 count", d, 32'd0);
    rd(2'd2, d); check("R1 status", d, 32'd0);

    // R10 timestamp load and advance, wrap
    wr(2'd0, 32'h0000_1000); wait_cyc(7); rd(2'd0, d);
    check("R10 stamp advance", d, 32'h0000_1007);
    wr(2'd0, 32'hFFFF_FFFE); wait_cyc(3); rd(2'd0, d);
    check("R10 stamp wrap", d, 32'h0000_0001);

    // R3 / R4 disabled load holds, R2 count reg write ignored
    wr(2'd1, {30'd5, 2'b00}); wait_cyc(6); rd(2'd3, d);
    check("R4 hold disabled", d, 32'd20);
    wr(2'd3, 32'd7); rd(2'd3, d);
    check("R2 count read-only", d, 32'd20);
    rd(2'd1, d); check("R3 readback", d, {30'd5, 2'b00});

    // R4 enable-only toggle
    wr(2'd1, {30'd5, 2'b01}); wait_cyc(3); rd(2'd3, d);
    check("R4 running", d, 32'd17);
    wr(2'd1, {30'd5, 2'b00}); wait_cyc(4); rd(2'd3, d);
    check("R4 stopped", d, 32'd20);

    // R6 one-shot, R7 pending, R8 irq
    wr(2'd1, {30'd2, 2'b11}); wait_cyc(8);
    check("R8 irq after oneshot", {31'b0, irq}, 32'd1);
    rd(2'd1, d); check("R6 enable cleared", d, {30'd2, 2'b10});
    rd(2'd3, d); check("R6 stopped at zero", d, 32'd0);
    wr(2'd2, 32'd0);
    check("R7 zero write no effect", {31'b0, irq}, 32'd1);
    wr(2'd2, 32'd1);
    check("R7 clear", {31'b0, irq}, 32'd0);
    rd(2'd2, d); check("R7 status reads 0", d, 32'd0);

    // R7 set beats clear in the same cycle: expiry at edge E+4
    wr(2'd1, {30'd1, 2'b11}); wait_cyc(3); wr(2'd2, 32'd1);
    check("R7 set wins", {31'b0, irq}, 32'd1);
    wr(2'd2, 32'd1);

    // R5 periodic second expiry
    wr(2'd1, {30'd3, 2'b01}); wait_cyc(12);
    check("R5 first expiry", {31'b0, irq}, 32'd1);
    wr(2'd2, 32'd1);            // clear at edge E+13
    wait_cyc(10);               // next expiry at E+24
    check("R5 before second", {31'b0, irq}, 32'd0);
    wait_cyc(1);
    check("R5 second expiry", {31'b0, irq}, 32'd1);

    // R9 write zero stops
    wr(2'd1, 32'd0); wr(2'd2, 32'd1); wait_cyc(20);
    check("R9 no irq", {31'b0, irq}, 32'd0);
    rd(2'd3, d); check("R9 count zero", d, 32'd0);
    rd(2'd1, d); check("R9 reload zero", d, 32'd0);

    // random runs checked against closed-form model (R4 R5 R6 R8)
    for (int it = 0; it < 40; it++) begin
      int n = int'($urandom_range(1, 6));
      bit os = 1'($urandom_range(0, 1));
      int j = int'($urandom_range(0, 30));
      wr(2'd1, 32'd0); wr(2'd2, 32'd1);
      wr(2'd1, {30'(n), os, 1'b1});
      wait_cyc(j);
      check("R8 random irq", {31'b0, irq}, {31'b0, (j >= 4 * n)});
      rd(2'd3, d); check("R4 random count", d, exp_count(n, os, j));
      rd(2'd1, d); check("R6 random reload", d, exp_reload(n, os, j + 1));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule